// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits in the column path of a synchronous DRAM. It keeps a small mode register that a mode-set command loads from a 14-bit key. That register holds the burst length, the wrap type, the CAS latency and a single-beat write option. Each time a read or write command arrives with a 9-bit starting column, the block walks through the column addresses of the burst, one per clock. It flags every valid beat and marks the final one.

Within the burst, sequential wrap adds the beat index to the low bits of the start column. Interleaved wrap XORs the index into those low bits. In both cases the upper column bits stay fixed. A full-page burst runs through all 512 columns and keeps wrapping until it is stopped. A new command, or a terminate or precharge on `burst_stop`, ends the current burst at once. The decoded CAS latency and wrap type are presented continuously to the read data path.

The sequencer has two states. In IDLE no burst runs. In RUN one beat is presented every cycle. Its transitions:
- IDLE to RUN on a start.
- RUN to RUN with a restart on a new start.
- RUN to RUN advancing one beat otherwise.
- RUN to IDLE after the final beat.
- RUN to IDLE on a stop.

Top module: `burst_col_gen`

## Requirements
- R1: After reset the outputs show burst length 1, sequential wrap (`burst_interleave`=0), `cas_lat`=2 and `mode_err`=0, with `col_valid`=0 and `col_out`=0.
- R2: A legal load decodes the key as follows. Bits 2:0 give the length (000=1, 001=2, 010=4, 011=8, 111=full page). Bit 3 gives the wrap type (0 sequential, 1 interleaved). Bits 6:4 give the CAS latency (001=1, 010=2, 011=3). `cas_lat` and `burst_interleave` show the new values in the cycle after the load, and a legal load clears `mode_err`.
- R3: Some loads are illegal: a reserved length or latency code, any of key bits 7, 8 or 10–13 set, or full page combined with interleaved wrap. An illegal load sets `mode_err` in the next cycle and leaves the previous mode in force. `mode_err` changes only on a load.
- R4: In the cycle after `burst_start`, `col_valid`=1 and `col_out` equals the start column. Beat k appears k cycles later. While `col_valid`=0, `col_out` reads 0.
- R5: In a sequential burst of length N, beat k equals the start column with its low log2(N) bits replaced by (low bits + k) mod N. The upper bits are unchanged.
- R6: In an interleaved burst of length N, beat k equals the start column XOR k.
- R7: `col_last` is 1 only on the final beat (beat N−1), and `col_valid` drops in the next cycle unless a new burst starts.
- R8: A full-page burst visits 512 columns in sequential order, wraps from 511 to 0, never raises `col_last`, and runs until stopped.
- R9: When key bit 9 is set, a write burst (`burst_write`=1) is exactly one beat long. Read bursts keep the programmed length.
- R10: `burst_stop` ends a running burst, so `col_valid`=0 in the next cycle. When no burst runs, it has no effect.
- R11: A `burst_start` during a burst abandons the old sequence and starts from its own column. A start in the same cycle as `burst_stop` wins.
- R12: A burst uses the mode that was in force at its start. A load in the same cycle as the start, or during the burst, does not change that burst's length or wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Mode-set strobe |
| mode_key | input | 14 | Mode key sampled with `mode_load` |
| burst_start | input | 1 | Read or write command strobe |
| start_col | input | 9 | Starting column of the burst |
| burst_write | input | 1 | 1 for a write command, 0 for a read |
| burst_stop | input | 1 | Terminate or precharge: ends the running burst |
| col_out | output | 9 | Current column address, 0 when not valid |
| col_valid | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | This beat is the final one of the burst |
| cas_lat | output | 2 | Decoded CAS latency, 1 to 3 |
| burst_interleave | output | 1 | Programmed wrap type, 1 for interleaved |
| mode_err | output | 1 | Last mode load was illegal |

## Verification
The bench targets the following corners, and the failure each would show:
- Wrap from the top of the low field to its bottom. A carry leaking into the upper bits would show as a column outside the aligned block.
- Interleave ordering. Swapping the XOR for an add would give a different beat order.
- The full-page wrap past column 511. A design that flagged a last beat there would end the burst early.
- Single-beat writes next to full-length reads, and illegal keys that must leave the old mode intact. A register that took a bad key would make the following bursts run at the wrong length.
- A restart or a stop mid-burst, a start and a stop in the same cycle, and a mode load during a burst. Each of these shows up as a stale column or a burst of the wrong length.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [2:0] {
        LEN_1,
        LEN_2,
        LEN_4,
        LEN_8,
        LEN_PAGE
    } len_e;

    typedef struct packed {
        len_e       len;
        logic       interleave;
        logic [1:0] cas;
        logic       single_wr;
    } mode_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } seq_state_e;

endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
    import bcg_pkg::*;
#(
    parameter int KEY_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [KEY_W-1:0] key,
    output mode_t            mode,
    output logic             err
);
    // Bits allowed to be non-zero: 6:0 and 9
    localparam logic [KEY_W-1:0] KEEP_MASK = KEY_W'(10'h27F);

    mode_t dec;
    logic  len_ok;
    logic  cl_ok;
    logic  legal;

    always_comb begin
        len_ok         = 1'b1;
        cl_ok          = 1'b1;
        dec.len        = LEN_1;
        dec.cas        = 2'd2;
        dec.interleave = key[3];
        dec.single_wr  = key[9];
        unique case (key[2:0])
            3'b000:  dec.len = LEN_1;
            3'b001:  dec.len = LEN_2;
            3'b010:  dec.len = LEN_4;
            3'b011:  dec.len = LEN_8;
            3'b111:  dec.len = LEN_PAGE;
            default: len_ok  = 1'b0;
        endcase
        unique case (key[6:4])
            3'b001:  dec.cas = 2'd1;
            3'b010:  dec.cas = 2'd2;
            3'b011:  dec.cas = 2'd3;
            default: cl_ok   = 1'b0;
        endcase
        legal = len_ok && cl_ok
             && ((key & ~KEEP_MASK) == '0)
             && !((dec.len == LEN_PAGE) && key[3]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '{len: LEN_1, interleave: 1'b0, cas: 2'd2, single_wr: 1'b0};
            err  <= 1'b0;
        end else if (load) begin
            if (legal) begin
                mode <= dec;
                err  <= 1'b0;
            end else begin
                err  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  len_e             len,
    input  logic             interleave,
    output logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] col
);
    always_comb begin
        unique case (len)
            LEN_1:   mask = '0;
            LEN_2:   mask = COL_W'(1);
            LEN_4:   mask = COL_W'(3);
            LEN_8:   mask = COL_W'(7);
            default: mask = '1;
        endcase
    end

    always_comb begin
        if (interleave)
            col = base ^ (idx & mask);
        else
            col = (base & ~mask) | ((base + idx) & mask);
    end

endmodule

// File: rtl/bcg_seq_fsm.sv
module bcg_seq_fsm
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             wr,
    input  logic             stop,
    input  mode_t            mode,
    input  logic [COL_W-1:0] beat_mask,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] idx_q,
    output len_e             len_q,
    output logic             ilv_q,
    output logic             valid,
    output logic             last
);
    seq_state_e       state_q, state_d;
    logic [COL_W-1:0] base_d, idx_d;
    len_e             len_d, eff_len;
    logic             ilv_d;

    assign eff_len = (wr && mode.single_wr) ? LEN_1 : mode.len;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            idx_q   <= '0;
            len_q   <= LEN_1;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            idx_q   <= idx_d;
            len_q   <= len_d;
            ilv_q   <= ilv_d;
        end
    end

    // outputs
    always_comb begin
        valid = (state_q == ST_RUN);
        last  = (state_q == ST_RUN) && (len_q != LEN_PAGE) && (idx_q == beat_mask);
    end

    // next state
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        idx_d   = idx_q;
        len_d   = len_q;
        ilv_d   = ilv_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    base_d  = start_col;
                    idx_d   = '0;
                    len_d   = eff_len;
                    ilv_d   = mode.interleave;
                end
            end
            ST_RUN: begin
                if (start) begin
                    base_d = start_col;
                    idx_d  = '0;
                    len_d  = eff_len;
                    ilv_d  = mode.interleave;
                end else if (stop || last) begin
                    state_d = ST_IDLE;
                end else begin
                    idx_d = idx_q + COL_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 9,
    parameter int KEY_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [KEY_W-1:0] mode_key,
    input  logic             burst_start,
    input  logic [COL_W-1:0] start_col,
    input  logic             burst_write,
    input  logic             burst_stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last,
    output logic [1:0]       cas_lat,
    output logic             burst_interleave,
    output logic             mode_err
);
    mode_t            mode;
    logic [COL_W-1:0] base_q, idx_q, mask, col;
    len_e             len_q;
    logic             ilv_q;

    bcg_mode_reg #(.KEY_W(KEY_W)) mode_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (mode_load),
        .key  (mode_key),
        .mode (mode),
        .err  (mode_err)
    );

    bcg_seq_fsm #(.COL_W(COL_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (burst_start),
        .start_col(start_col),
        .wr       (burst_write),
        .stop     (burst_stop),
        .mode     (mode),
        .beat_mask(mask),
        .base_q   (base_q),
        .idx_q    (idx_q),
        .len_q    (len_q),
        .ilv_q    (ilv_q),
        .valid    (col_valid),
        .last     (col_last)
    );

    bcg_col_map #(.COL_W(COL_W)) map_i (
        .base      (base_q),
        .idx       (idx_q),
        .len       (len_q),
        .interleave(ilv_q),
        .mask      (mask),
        .col       (col)
    );

    assign col_out          = col_valid ? col : '0;
    assign cas_lat          = mode.cas;
    assign burst_interleave = mode.interleave;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W = 9,
    parameter int KEY_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_load,
    input logic [KEY_W-1:0] mode_key,
    input logic             burst_start,
    input logic [COL_W-1:0] start_col,
    input logic             burst_stop,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             col_last,
    input logic [1:0]       cas_lat,
    input logic             mode_err
);
    assert_start_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> (col_valid && col_out == $past(start_col)));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (col_out == '0));

    assert_stop_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !burst_start) |=> !col_valid);

    assert_last_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !burst_start) |=> !col_valid);

    assert_last_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    assert_bad_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && (|mode_key[8:7])) |=> mode_err);

    assert_err_only_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> $stable(mode_err));

    assert_cl_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cas_lat != 2'd0);

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W), .KEY_W(KEY_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_load  (mode_load),
    .mode_key   (mode_key),
    .burst_start(burst_start),
    .start_col  (start_col),
    .burst_stop (burst_stop),
    .col_out    (col_out),
    .col_valid  (col_valid),
    .col_last   (col_last),
    .cas_lat    (cas_lat),
    .mode_err   (mode_err)
);

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [13:0] mode_key = '0;
    logic       burst_start = 1'b0;
    logic [8:0] start_col = '0;
    logic       burst_write = 1'b0;
    logic       burst_stop = 1'b0;
    logic [8:0] col_out;
    logic       col_valid, col_last, burst_interleave, mode_err;
    logic [1:0] cas_lat;

    always #2 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_key(mode_key),
        .burst_start(burst_start), .start_col(start_col), .burst_write(burst_write),
        .burst_stop(burst_stop), .col_out(col_out), .col_valid(col_valid),
        .col_last(col_last), .cas_lat(cas_lat), .burst_interleave(burst_interleave),
        .mode_err(mode_err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int m_len = 1, m_int = 0, m_cl = 2, m_sw = 0, m_err = 0;
    int m_act = 0, m_base = 0, m_idx = 0, m_blen = 1, m_bint = 0;

    function automatic int exp_col();
        int off;
        if (!m_act) return 0;
        if (m_bint) return m_base ^ m_idx;
        off = m_base % m_blen;
        return m_base - off + ((off + m_idx) % m_blen);
    endfunction

    function automatic int exp_last();
        return (m_act && m_blen != 512 && m_idx == m_blen - 1) ? 1 : 0;
    endfunction

    task automatic model_step();
        int eff, lc, cc, nl, nc;
        bit ok;
        eff = (burst_write && m_sw) ? 1 : m_len;
        if (burst_start) begin
            m_act = 1; m_base = start_col; m_idx = 0; m_blen = eff; m_bint = m_int;
        end else if (burst_stop) begin
            m_act = 0;
        end else if (m_act) begin
            if (exp_last()) m_act = 0;
            else m_idx = (m_idx + 1) % 512;
        end
        if (mode_load) begin
            lc = mode_key[2:0]; cc = mode_key[6:4]; ok = 1;
            case (lc)
                0: nl = 1; 1: nl = 2; 2: nl = 4; 3: nl = 8; 7: nl = 512;
                default: begin nl = 0; ok = 0; end
            endcase
            if (cc >= 1 && cc <= 3) nc = cc; else begin nc = 0; ok = 0; end
            if ((mode_key & ~14'h027F) != 0) ok = 0;
            if (nl == 512 && mode_key[3]) ok = 0;
            if (ok) begin
                m_len = nl; m_int = mode_key[3]; m_cl = nc; m_sw = mode_key[9]; m_err = 0;
            end else m_err = 1;
        end
    endtask

    task automatic compare();
        int ec, el;
        ec = exp_col(); el = exp_last();
        checks++;
        if (col_valid !== 1'(m_act) || col_out !== 9'(ec) || col_last !== 1'(el) ||
            cas_lat !== 2'(m_cl) || burst_interleave !== 1'(m_int) || mode_err !== 1'(m_err)) begin
            errors++;
            $display("FAIL %s t=%0t actual v=%0d col=%0d last=%0d cl=%0d il=%0d err=%0d expected v=%0d col=%0d last=%0d cl=%0d il=%0d err=%0d",
                cur_req, $time, col_valid, col_out, col_last, cas_lat, burst_interleave, mode_err,
                m_act, ec, el, m_cl, m_int, m_err);
        end
    endtask

    task automatic tick(input bit ld, input logic [13:0] key, input bit st,
                        input logic [8:0] col, input bit wr, input bit sp);
        mode_load = ld; mode_key = key; burst_start = st; start_col = col;
        burst_write = wr; burst_stop = sp;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, '0, 0, '0, 0, 0);
    endtask

    task automatic load(input logic [13:0] key);
        tick(1, key, 0, '0, 0, 0);
    endtask

    task automatic start(input logic [8:0] col, input bit wr);
        tick(0, '0, 1, col, wr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        compare();
        idle(2);

        cur_req = "R4";  start(9'h0A5, 0); idle(2);            // BL1 after reset
        cur_req = "R2";  load(14'h032); idle(1);               // CL3, BL4, sequential
        cur_req = "R5";  start(9'h0A5, 0); idle(5);            // A5 A6 A7 A4
        cur_req = "R7";  start(9'h1FF, 0); idle(5);
        cur_req = "R2";  load(14'h03A);                        // BL4 interleaved
        cur_req = "R6";  start(9'h0A5, 0); idle(5);            // A5 A4 A7 A6
        cur_req = "R6";  load(14'h01B); start(9'h013, 0); idle(9);
        cur_req = "R5";  load(14'h013); start(9'h01D, 1); idle(9);
        cur_req = "R5";  load(14'h011); start(9'h1F1, 0); idle(3);

        cur_req = "R3";  load(14'h0132); idle(2);              // bit 8 set
        cur_req = "R3";  load(14'h0402); idle(1);              // CL code 0
        cur_req = "R3";  load(14'h0034); idle(1);              // length code 4
        cur_req = "R3";  load(14'h003F); idle(1);              // page + interleave
        cur_req = "R3";  load(14'h2012); idle(1);              // bit 13 set
        cur_req = "R3";  start(9'h040, 0); idle(3);            // old BL2 still in force
        cur_req = "R2";  load(14'h0012); idle(1);

        cur_req = "R8";  load(14'h0037); start(9'h1FE, 0); idle(520);
        cur_req = "R10"; tick(0, '0, 0, '0, 0, 1); idle(2);
        cur_req = "R10"; tick(0, '0, 0, '0, 0, 1); idle(1);    // stop while idle

        cur_req = "R9";  load(14'h0232); start(9'h055, 1); idle(3);
        cur_req = "R9";  start(9'h055, 0); idle(5);
        cur_req = "R9";  load(14'h0233); start(9'h077, 1); start(9'h078, 0); idle(9);

        cur_req = "R11"; load(14'h0033); start(9'h010, 0); idle(2);
        cur_req = "R11"; start(9'h0C6, 0); idle(2);
        cur_req = "R11"; tick(0, '0, 1, 9'h1E3, 0, 1); idle(9);
        cur_req = "R10"; start(9'h020, 0); idle(1); tick(0, '0, 0, '0, 0, 1); idle(2);

        cur_req = "R12"; tick(1, 14'h0011, 1, 9'h101, 0, 0); idle(9);
        cur_req = "R12"; load(14'h003A); start(9'h02B, 0); load(14'h0010); idle(5);
        cur_req = "R12"; start(9'h02B, 0); idle(2);

        cur_req = "R11";
        begin
            logic [15:0] lf = 16'hACE1;
            logic [2:0]  lcode;
            for (int i = 0; i < 3000; i++) begin
                bit ld, st, sp;
                logic [13:0] k;
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                ld = (lf[4:0] == 5'd3);
                st = (lf[7:6] == 2'd0);
                sp = (lf[11:8] == 4'd5);
                case (lf[14:12] % 5)
                    0: lcode = 3'd0; 1: lcode = 3'd1; 2: lcode = 3'd2;
                    3: lcode = 3'd3; default: lcode = 3'd7;
                endcase
                k = {4'd0, lf[2], 2'd0, 1'b0, 2'(lf[9:8] % 3 + 1), lf[5], lcode};
                tick(ld, k, st, lf[15:7], lf[1], sp);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule